// File: doc/BRIEF.md
# Priority Pin-Function Multiplexer Port

This block is an eight-pin general-purpose I/O port in which several CAN controllers and one SPI controller can claim individual pins. Each pin has a fixed precedence chain of candidate peripheral signals. The highest candidate whose enable flag is set owns the pin, and plain I/O controlled by the port's latch and direction register owns it only when no candidate is enabled. Receive-only signals release the pad. Transmit signals drive it. SPI lines are bidirectional and follow the SPI controller's own output-enable.

Every pad input passes through a two-flop synchroniser. The synchronised value feeds the register read path and the receive lines sent back to the peripherals. A small register bus gives access to three registers: the output latch, the direction register, and a read-only view of the synchronised pads.

Top module: `pmux_port`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the latch and the direction register are all zeros, so every pad output-enable is low while `fn_en` is zero.
- R2: With no function enabled on a pin, `pad_o` equals that pin's latch bit and `pad_oe` equals its direction bit.
- R3: A read at address 0 returns, per bit, the latch when the direction bit is 1 and the synchronised pad when it is 0. Address 1 reads the direction register and address 3 reads zero.
- R4: A read at address 2 returns all eight synchronised pads, whatever the direction. A write to address 2 changes neither the latch nor the direction register.
- R5: A pad change becomes visible to reads and receive lines after exactly two rising clock edges.
- R6: Enable bit 0 (CAN-A native) makes pin 0 the CAN-A receive line and pin 1 the CAN-A transmit line (`can_tx[0]`).
- R7: Pin 4 precedence, highest first: CAN-C receive (enable bit 2), routed CAN-A receive (bit 4), routed CAN-E receive (bit 5), SPI line 2 (bit 6), then I/O.
- R8: Pin 5 precedence: CAN-C transmit (`can_tx[2]`, bit 2), routed CAN-A transmit (`can_tx[0]`, bit 4), SPI line 3 (bit 6), then I/O.
- R9: Pin 2 precedence: CAN-B receive (bit 1), routed CAN-A receive (bit 3), SPI line 0 (bit 6), then I/O. Pin 3 precedence: CAN-B transmit (`can_tx[1]`, bit 1), routed CAN-A transmit (bit 3), SPI line 1 (bit 6), then I/O.
- R10: When a receive signal owns a pin, `pad_oe` is 0 and `pad_o` is 0. When a transmit signal owns it, `pad_oe` is 1 and `pad_o` is its `can_tx` bit. When an SPI line owns it, the pin takes `spi_do` and `spi_oe` of that line.
- R11: `can_rx` bits 0..3 belong to CAN-A, B, C and E. Each bit carries the synchronised pad of the pin that the controller's receive signal owns. CAN-A prefers pin 0, then pin 2, then pin 4. A controller that owns no pin reads 1.
- R12: Latch writes take effect while a peripheral owns the pin, and the written value drives the pad once the peripheral is disabled.
- R13: Pins 6 and 7 are always plain I/O.
- R14: `spi_di[k]` carries the synchronised pad of the pin that SPI line k owns (line 0 to pin 2, line 1 to pin 3, line 2 to pin 4, line 3 to pin 5), or 1 when that line owns no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_i | input | 8 | Raw pad input levels |
| pad_o | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output-enables |
| fn_en | input | 7 | Function enables (bit order given in R6 to R9) |
| can_tx | input | 3 | Transmit values of CAN-A, B, C |
| can_rx | output | 4 | Receive lines to CAN-A, B, C, E |
| spi_do | input | 4 | SPI line output values |
| spi_oe | input | 4 | SPI line output-enables |
| spi_di | output | 4 | SPI line input values |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |

## Verification
Some properties are checked on every cycle: the reset values, plain I/O passthrough on an unclaimed pin, the two-edge pad delay, pins 6 and 7 staying plain I/O, the fixed roles of pins 0 and 1 under CAN-A, idle receive lines when nothing is enabled, and the read-only nature of address 2. The precedence chains on pins 2 to 5 and the choice among several candidate pins for CAN-A receive can only be shown by the bench's scenarios. The bench sweeps all 128 enable combinations against a model built from the requirements. It also covers the mixed read path, the latch held while a peripheral owns a pin, and the exact cycle at which a pad edge appears.

// File: rtl/pmux_pkg.sv
// Shared constants, types and the per-pin precedence table of the port.
// Assumes: eight pins, at most four candidate signals per pin, slot 0 highest.
package pmux_pkg;
    localparam int NPIN   = 8;
    localparam int NSLOT  = 4;
    localparam int NEN    = 7;
    localparam int NCANRX = 4;
    localparam int NCANTX = 3;
    localparam int NSPI   = 4;
    localparam int ADDR_W = 2;
    localparam int SYNC_DEPTH = 2;

    // enable bit positions
    localparam int EN_CA  = 0;
    localparam int EN_CB  = 1;
    localparam int EN_CC  = 2;
    localparam int EN_RAL = 3;
    localparam int EN_RAH = 4;
    localparam int EN_RE  = 5;
    localparam int EN_SP  = 6;

    // controller indices
    localparam int CAN_A = 0;
    localparam int CAN_B = 1;
    localparam int CAN_C = 2;
    localparam int CAN_E = 3;

    typedef enum logic [1:0] {K_NONE, K_RX, K_TX, K_BIDIR} kind_t;

    typedef struct packed {
        kind_t      kind;
        logic [2:0] en;
        logic [1:0] src;
    } slot_t;

    // Returns the candidate at a given precedence slot of a pin.
    function automatic slot_t slot_map(input int pin, input int slot);
        slot_t s;
        s = '{K_NONE, 3'd0, 2'd0};
        case (pin)
            0: if (slot == 0) s = '{K_RX, 3'(EN_CA), 2'(CAN_A)};
            1: if (slot == 0) s = '{K_TX, 3'(EN_CA), 2'(CAN_A)};
            2: case (slot)
                   0: s = '{K_RX,    3'(EN_CB),  2'(CAN_B)};
                   1: s = '{K_RX,    3'(EN_RAL), 2'(CAN_A)};
                   2: s = '{K_BIDIR, 3'(EN_SP),  2'd0};
                   default: ;
               endcase
            3: case (slot)
                   0: s = '{K_TX,    3'(EN_CB),  2'(CAN_B)};
                   1: s = '{K_TX,    3'(EN_RAL), 2'(CAN_A)};
                   2: s = '{K_BIDIR, 3'(EN_SP),  2'd1};
                   default: ;
               endcase
            4: case (slot)
                   0: s = '{K_RX,    3'(EN_CC),  2'(CAN_C)};
                   1: s = '{K_RX,    3'(EN_RAH), 2'(CAN_A)};
                   2: s = '{K_RX,    3'(EN_RE),  2'(CAN_E)};
                   3: s = '{K_BIDIR, 3'(EN_SP),  2'd2};
                   default: ;
               endcase
            5: case (slot)
                   0: s = '{K_TX,    3'(EN_CC),  2'(CAN_C)};
                   1: s = '{K_TX,    3'(EN_RAH), 2'(CAN_A)};
                   2: s = '{K_BIDIR, 3'(EN_SP),  2'd3};
                   default: ;
               endcase
            default: ;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/pmux_sync.sv
// Multi-stage synchroniser for the pad inputs.
// Assumes: stages carry no reset, so the input view always shows the
// present pad state, even straight after reset.
module pmux_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // shift the pad sample through the stage chain
    always_ff @(posedge clk) begin
        stg[0] <= din;
        for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pmux_pin_arb.sv
// Per-pin owner selection: the lowest claimed slot wins, otherwise the
// pin is plain I/O from the latch and direction bits.
// Assumes: claim/val/drv_oe are already resolved per slot by the caller.
module pmux_pin_arb #(
    parameter int NSLOT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] claim,
    input  logic [NSLOT-1:0] val,
    input  logic [NSLOT-1:0] drv_oe,
    input  logic             gpio_d,
    input  logic             gpio_dir,
    output logic             pad_o,
    output logic             pad_oe,
    output logic [NSLOT-1:0] win
);
    // pick the highest-precedence claimant, falling back to plain I/O
    always_comb begin
        win    = '0;
        pad_o  = gpio_d;
        pad_oe = gpio_dir;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (claim[s]) begin
                win    = '0;
                win[s] = 1'b1;
                pad_o  = val[s];
                pad_oe = drv_oe[s];
            end
        end
    end

    // R2
    gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim == '0) |-> (pad_o == gpio_d && pad_oe == gpio_dir));
endmodule

// File: rtl/pmux_regs.sv
// Latch, direction and input-view registers with a simple write strobe
// and combinational read mux.
// Assumes: address 0 latch, 1 direction, 2 input view, 3 reads zero.
module pmux_regs #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pad_s,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(2);

    // update latch and direction on writes, clear both on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_DATA) data_q <= bus_wdata;
            if (bus_addr == A_DIR)  dir_q  <= bus_wdata;
        end
    end

    // select read data; latch or pad per bit by direction at address 0
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = (dir_q & data_q) | (~dir_q & pad_s);
            A_DIR:   bus_rdata = dir_q;
            A_IN:    bus_rdata = pad_s;
            default: bus_rdata = '0;
        endcase
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_q == '0 && dir_q == '0));

    // R4
    in_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IN) |=> ($stable(data_q) && $stable(dir_q)));
endmodule

// File: rtl/pmux_port.sv
// Port top: synchronises pads, resolves each pin's owner through the
// precedence table, and routes synchronised pads back to the peripherals.
// Assumes: table in pmux_pkg; pins without candidates are plain I/O.
module pmux_port
    import pmux_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pad_i,
    output logic [NPIN-1:0]   pad_o,
    output logic [NPIN-1:0]   pad_oe,
    input  logic [NEN-1:0]    fn_en,
    input  logic [NCANTX-1:0] can_tx,
    output logic [NCANRX-1:0] can_rx,
    input  logic [NSPI-1:0]   spi_do,
    input  logic [NSPI-1:0]   spi_oe,
    output logic [NSPI-1:0]   spi_di,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata
);
    logic [NPIN-1:0]  pad_s;
    logic [NPIN-1:0]  data_q;
    logic [NPIN-1:0]  dir_q;
    logic [NSLOT-1:0] win_m [NPIN];

    pmux_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .din (pad_i),
        .dout(pad_s)
    );

    pmux_regs #(.WIDTH(NPIN), .ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pad_s    (pad_s),
        .bus_rdata(bus_rdata),
        .data_q   (data_q),
        .dir_q    (dir_q)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [NSLOT-1:0] claim;
        logic [NSLOT-1:0] val;
        logic [NSLOT-1:0] drv_oe;

        // resolve each slot's claim and drive from the table
        always_comb begin
            slot_t t;
            for (int s = 0; s < NSLOT; s++) begin
                t = slot_map(p, s);
                claim[s]  = (t.kind != K_NONE) && fn_en[t.en];
                val[s]    = 1'b0;
                drv_oe[s] = 1'b0;
                case (t.kind)
                    K_TX: begin
                        val[s]    = can_tx[t.src];
                        drv_oe[s] = 1'b1;
                    end
                    K_BIDIR: begin
                        val[s]    = spi_do[t.src];
                        drv_oe[s] = spi_oe[t.src];
                    end
                    default: ;
                endcase
            end
        end

        pmux_pin_arb #(.NSLOT(NSLOT)) arb_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .claim   (claim),
            .val     (val),
            .drv_oe  (drv_oe),
            .gpio_d  (data_q[p]),
            .gpio_dir(dir_q[p]),
            .pad_o   (pad_o[p]),
            .pad_oe  (pad_oe[p]),
            .win     (win_m[p])
        );
    end

    // route owned pads back; lower pin numbers take priority
    always_comb begin
        slot_t r;
        can_rx = '1;
        spi_di = '1;
        for (int p = NPIN - 1; p >= 0; p--) begin
            for (int s = 0; s < NSLOT; s++) begin
                r = slot_map(p, s);
                if (win_m[p][s]) begin
                    if (r.kind == K_RX)         can_rx[r.src] = pad_s[p];
                    else if (r.kind == K_BIDIR) spi_di[r.src] = pad_s[p];
                end
            end
        end
    end

    if (SYNC_STAGES == 2) begin : g_lag_chk
        // R5
        sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_addr == ADDR_W'(2) |-> bus_rdata == $past(pad_i, 2));
    end

    // R13
    upper_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[7:6] == dir_q[7:6] && pad_o[7:6] == data_q[7:6]);

    // R6
    can_a_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fn_en[EN_CA] |-> (!pad_oe[0] && pad_oe[1] && pad_o[1] == can_tx[CAN_A]));

    // R11
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_en == '0) |-> (can_rx == '1 && spi_di == '1));
endmodule

// File: tb/pmux_port_tb.sv
module pmux_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pad_i = 8'hA5;
    logic [7:0] pad_o, pad_oe;
    logic [6:0] fn_en = '0;
    logic [2:0] can_tx = '0;
    logic [3:0] can_rx;
    logic [3:0] spi_do = '0, spi_oe = '0, spi_di;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pmux_port dut_i (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
        .fn_en(fn_en), .can_tx(can_tx), .can_rx(can_rx), .spi_do(spi_do),
        .spi_oe(spi_oe), .spi_di(spi_di), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Expected pad and routing values, built from the precedence rules.
    task automatic model(input logic [6:0] en, input logic [7:0] dat, input logic [7:0] dir,
                         input logic [7:0] pad, input logic [2:0] ctx,
                         input logic [3:0] sdo, input logic [3:0] soe,
                         output logic [7:0] po, output logic [7:0] poe,
                         output logic [3:0] crx, output logic [3:0] sdi);
        po = dat; poe = dir; crx = 4'hF; sdi = 4'hF;
        if (en[0]) begin po[0] = 0; poe[0] = 0; po[1] = ctx[0]; poe[1] = 1; end
        if (en[1])      begin po[2] = 0; poe[2] = 0; end
        else if (en[3]) begin po[2] = 0; poe[2] = 0; end
        else if (en[6]) begin po[2] = sdo[0]; poe[2] = soe[0]; sdi[0] = pad[2]; end
        if (en[1])      begin po[3] = ctx[1]; poe[3] = 1; end
        else if (en[3]) begin po[3] = ctx[0]; poe[3] = 1; end
        else if (en[6]) begin po[3] = sdo[1]; poe[3] = soe[1]; sdi[1] = pad[3]; end
        if (en[2] | en[4] | en[5]) begin po[4] = 0; poe[4] = 0; end
        else if (en[6]) begin po[4] = sdo[2]; poe[4] = soe[2]; sdi[2] = pad[4]; end
        if (en[2])      begin po[5] = ctx[2]; poe[5] = 1; end
        else if (en[4]) begin po[5] = ctx[0]; poe[5] = 1; end
        else if (en[6]) begin po[5] = sdo[3]; poe[5] = soe[3]; sdi[3] = pad[5]; end
        // receive routing
        if (en[1]) crx[1] = pad[2];
        if (en[2]) crx[2] = pad[4];
        else if (!en[4] && en[5]) crx[3] = pad[4];
        if (en[0]) crx[0] = pad[0];
        else if (!en[1] && en[3]) crx[0] = pad[2];
        else if (!en[2] && en[4]) crx[0] = pad[4];
    endtask

    initial begin
        logic [7:0] rd;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        bus_read(2'd1, rd); check("R1 dir after reset", rd, 8'h00);
        bus_read(2'd0, rd); check("R3 data read of input pins", rd, 8'hA5);
        bus_read(2'd2, rd); check("R4 input view after reset", rd, 8'hA5);
        bus_read(2'd3, rd); check("R3 unused address", rd, 8'h00);

        // plain I/O sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d, r, p;
            d = 8'(i * 37 + 3); r = 8'(i * 91 + 5); p = 8'(i * 53 + 11);
            @(negedge clk) pad_i = p;
            bus_write(2'd0, d);
            bus_write(2'd1, r);
            @(negedge clk); #1;
            check("R2 pad_o follows latch", pad_o, d);
            check("R2 pad_oe follows dir", pad_oe, r);
            check("R13 upper pins plain", {pad_o[7:6], pad_oe[7:6]}, {d[7:6], r[7:6]});
            bus_read(2'd0, rd); check("R3 mixed data read", rd, (r & d) | (~r & p));
            bus_read(2'd1, rd); check("R3 dir read", rd, r);
            bus_read(2'd2, rd); check("R4 input view", rd, p);
        end

        // R4 write to input view ignored
        bus_write(2'd0, 8'h3C);
        bus_write(2'd1, 8'hC3);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd1, rd); check("R4 dir unchanged by addr 2 write", rd, 8'hC3);
        check("R4 latch unchanged by addr 2 write", pad_o, 8'h3C);

        // R5 exact two-edge lag
        bus_read(2'd2, rd);
        pad_i = 8'h5A;
        @(posedge clk); @(negedge clk); #1;
        check("R5 one edge: old value", bus_rdata, rd);
        @(posedge clk); @(negedge clk); #1;
        check("R5 two edges: new value", bus_rdata, 8'h5A);

        // full enable sweep
        for (int e = 0; e < 128; e++) begin
            for (int k = 0; k < 2; k++) begin
                logic [7:0] p, d, r, xpo, xpoe;
                logic [3:0] xcrx, xsdi;
                p = 8'(e * 29 + k * 113);
                d = 8'(~p ^ 8'(e));
                r = 8'(e * 7 + k);
                bus_write(2'd0, d);
                bus_write(2'd1, r);
                @(negedge clk);
                fn_en  = 7'(e);
                can_tx = 3'(e + k * 5);
                spi_do = 4'(e * 3 + k);
                spi_oe = 4'(e * 5 + k * 9);
                pad_i  = p;
                @(posedge clk); @(posedge clk); @(negedge clk); #1;
                model(7'(e), d, r, p, can_tx, spi_do, spi_oe, xpo, xpoe, xcrx, xsdi);
                check("R6 R7 R8 R9 R13 pad_o", pad_o, xpo);
                check("R10 pad_oe", pad_oe, xpoe);
                check("R11 can_rx", can_rx, xcrx);
                check("R14 spi_di", spi_di, xsdi);
            end
        end

        // R12 latch written under ownership, visible after release
        @(negedge clk) fn_en = 7'b0000001; can_tx = 3'b000;
        bus_write(2'd1, 8'hFF);
        bus_write(2'd0, 8'hFF);
        #1 check("R12 owner still drives pin1", pad_o[1], 1'b0);
        @(negedge clk) fn_en = '0;
        #1 check("R12 latch reaches pads after release", pad_o, 8'hFF);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule